// File: doc/BRIEF.md
# Dual Ancillary Data Insertion FIFO

This block buffers ancillary words headed for a two-stream video link. It holds one queue for the luma stream and one for the chroma stream. Writes arrive on their own write clock, and a select line steers each write to one of the two queues. Reads run on the pixel clock. Each word read from a queue is presented on the half of the output bus that matches its stream, so that downstream logic can splice it into the video.

Two sources can drive the queue clear and the read request. In external mode they come from dedicated active-low pins. In internal mode a small line-timing controller drives them from blanking strobes. Reads then run only from the start-of-blanking strobe to the end-of-blanking strobe, and the end strobe clears both queues. Words for a line's blanking gap are loaded during the active video of the line before it. The full and empty flags can be forced inactive with an active-low flag enable.

Top module: `anc_dual_fifo`

## Requirements
- R1: A write happens on a rising `wr_clk` edge only when `wr_en_n` is 0. While `wr_en_n` is 1, nothing is stored and the write pointer holds.
- R2: With `sel_luma` = 1, a write stores `wr_data[19:10]` into the luma queue, and a read pops the luma queue onto `rd_data[19:10]`. With `sel_luma` = 0, a write stores `wr_data[9:0]` into the chroma queue, and a read pops the chroma queue onto `rd_data[9:0]`. The half of `rd_data` that was not popped keeps its value.
- R3: In external mode (`int_mode` = 0), each rising `rd_clk` edge with `rd_en_n` = 0 pops one word. `rd_vld` is 1 in the cycle after a pop edge. While `rd_en_n` is 1, nothing is popped.
- R4: Each queue holds 64 words and returns them in the order they were written.
- R5: `full[1]` (luma) and `full[0]` (chroma) are produced in the `wr_clk` domain. A write to a full queue is dropped and leaves its pointer unchanged.
- R6: `empty[1]` (luma) and `empty[0]` (chroma) are produced in the `rd_clk` domain. A read from an empty queue produces no `rd_vld`, leaves `rd_data` unchanged and does not move the pointer.
- R7: In external mode, `fifo_clr_n` = 0 on a rising `rd_clk` edge clears both queues, and all pointers return to the start. For the next 8 pixel clocks both queues report empty, and writes are dropped while the clear reaches the write side.
- R8: `flag_oe_n` = 1 forces every bit of `full` and `empty` to 0. It has no effect on storage or reading.
- R9: In internal mode, `rd_en_n` and `fifo_clr_n` are ignored. Reading runs on each pixel clock from the edge after a `blank_start` strobe until a `blank_end` strobe.
- R10: In internal mode, a `blank_end` strobe stops reading at that edge and clears both queues, discarding any words not yet read.
- R11: After `arst_n` is asserted, `empty` = 2'b11, `full` = 2'b00, `rd_vld` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous reset, active low |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write enable, active low |
| sel_luma | input | 1 | 1 selects the luma queue, 0 selects the chroma queue |
| wr_data | input | 20 | Write data: luma in [19:10], chroma in [9:0] |
| rd_clk | input | 1 | Pixel clock |
| rd_en_n | input | 1 | External read enable, active low |
| fifo_clr_n | input | 1 | External synchronous clear, active low |
| int_mode | input | 1 | 1 selects internal blanking-driven control |
| blank_start | input | 1 | Start-of-blanking strobe (internal mode) |
| blank_end | input | 1 | End-of-blanking strobe (internal mode) |
| flag_oe_n | input | 1 | Flag output enable, active low |
| rd_data | output | 20 | Read data: luma in [19:10], chroma in [9:0] |
| rd_vld | output | 1 | A word was popped at the previous edge |
| full | output | 2 | Full flags, [1] luma, [0] chroma |
| empty | output | 2 | Empty flags, [1] luma, [0] chroma |

## Verification
The hardest situation to reach is the end of a blanking gap in internal mode with words still queued. The bench loads four luma words and opens the gap with a strobe. It counts the words as they appear and closes the gap directly after the second. Exactly two words must arrive, and the queue must read empty once the clear has settled. The full boundary is reached by holding the write enable for 66 cycles. The two extra writes must not appear when all 64 words are read back.

// File: rtl/anc_dual_fifo.sv
module anc_dual_fifo #(
  parameter int W = 10,
  parameter int AW = 6,
  parameter int CLR_HOLD = 8
) (
  input  logic           arst_n,
  input  logic           wr_clk,
  input  logic           wr_en_n,
  input  logic           sel_luma,
  input  logic [2*W-1:0] wr_data,
  input  logic           rd_clk,
  input  logic           rd_en_n,
  input  logic           fifo_clr_n,
  input  logic           int_mode,
  input  logic           blank_start,
  input  logic           blank_end,
  input  logic           flag_oe_n,
  output logic [2*W-1:0] rd_data,
  output logic           rd_vld,
  output logic [1:0]     full,
  output logic [1:0]     empty
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(CLR_HOLD + 1);
  localparam logic [AW:0] ONE = 1;

  function automatic logic [AW:0] gry(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          rd_act, guard, wclr, rclr, ren;
  logic [CW-1:0] gcnt;
  logic [1:0]    wclr_s, full_i, empty_i, rd_go;
  logic [2*AW+1:0] wbin_all, rbin_all;

  assign rclr = int_mode ? blank_end : !fifo_clr_n;
  assign ren  = int_mode ? rd_act : !rd_en_n;
  assign wclr = wclr_s[1];

  always_ff @(posedge rd_clk or negedge arst_n)
    if (!arst_n) begin
      rd_act <= 1'b0;
      gcnt   <= '0;
      guard  <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      rd_act <= int_mode && !blank_end && (rd_act || blank_start);
      if (rclr) gcnt <= CW'(CLR_HOLD);
      else if (guard) gcnt <= gcnt - 1'b1;
      guard  <= rclr || (gcnt > 1);
      rd_vld <= |rd_go;
    end

  always_ff @(posedge wr_clk or negedge arst_n)
    if (!arst_n) wclr_s <= '0;
    else wclr_s <= {wclr_s[0], guard};

  for (genvar g = 0; g < 2; g++) begin : ch
    localparam int LO = g * W;
    localparam bit IS_L = (g == 1);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] dq;
    logic [AW:0]  wbin, rbin, wgray, rgray, wq1, wq2, rq1, rq2;
    logic         wr_go;

    assign full_i[g]  = wgray == {~rq2[AW:AW-1], rq2[AW-2:0]};
    assign empty_i[g] = guard || (rgray == wq2);
    assign wr_go      = !wr_en_n && (sel_luma == IS_L) && !full_i[g] && !wclr;
    assign rd_go[g]   = ren && (sel_luma == IS_L) && !empty_i[g] && !rclr;
    assign rd_data[LO +: W] = dq;
    assign wbin_all[g*(AW+1) +: AW+1] = wbin;
    assign rbin_all[g*(AW+1) +: AW+1] = rbin;

    always_ff @(posedge wr_clk)
      if (wr_go) mem[wbin[AW-1:0]] <= wr_data[LO +: W];

    always_ff @(posedge wr_clk or negedge arst_n)
      if (!arst_n) begin
        wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      end else begin
        rq1 <= rgray;
        rq2 <= rq1;
        if (wclr) begin
          wbin <= '0; wgray <= '0;
        end else if (wr_go) begin
          wbin  <= wbin + ONE;
          wgray <= gry(wbin + ONE);
        end
      end

    always_ff @(posedge rd_clk or negedge arst_n)
      if (!arst_n) begin
        rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; dq <= '0;
      end else begin
        wq1 <= wgray;
        wq2 <= wq1;
        if (rclr) begin
          rbin <= '0; rgray <= '0;
        end else if (rd_go[g]) begin
          rbin  <= rbin + ONE;
          rgray <= gry(rbin + ONE);
          dq    <= mem[rbin[AW-1:0]];
        end
      end
  end

  assign full  = flag_oe_n ? 2'b00 : (full_i & {2{!wclr}});
  assign empty = flag_oe_n ? 2'b00 : empty_i;
endmodule

// File: rtl/anc_dual_fifo_chk.sv
module anc_dual_fifo_chk #(
  parameter int AW = 6
) (
  input logic          arst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en_n,
  input logic          sel_luma,
  input logic          rd_en_n,
  input logic          fifo_clr_n,
  input logic          int_mode,
  input logic          blank_end,
  input logic          flag_oe_n,
  input logic          rd_vld,
  input logic [1:0]    full,
  input logic [1:0]    empty,
  input logic          wclr,
  input logic [2*AW+1:0] wbin_all,
  input logic [2*AW+1:0] rbin_all
);
  // R1
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (wr_en_n && !wclr) |=> $stable(wbin_all));

  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (!flag_oe_n && full[1] && !wr_en_n && sel_luma && !wclr) |=> $stable(wbin_all[2*AW+1:AW+1]));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    rd_vld |-> $past(flag_oe_n || empty != 2'b11));

  // R3
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (!int_mode && rd_en_n) |=> !rd_vld);

  // R7
  ext_clr_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (!int_mode && !fifo_clr_n) |=> (rbin_all == '0 && !rd_vld));

  // R10
  blank_end_clr_chk: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (int_mode && blank_end) |=> (rbin_all == '0 && !rd_vld));
endmodule

bind anc_dual_fifo anc_dual_fifo_chk #(.AW(AW)) u_chk (
  .arst_n(arst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en_n(wr_en_n),
  .sel_luma(sel_luma), .rd_en_n(rd_en_n), .fifo_clr_n(fifo_clr_n),
  .int_mode(int_mode), .blank_end(blank_end), .flag_oe_n(flag_oe_n),
  .rd_vld(rd_vld), .full(full), .empty(empty), .wclr(wclr),
  .wbin_all(wbin_all), .rbin_all(rbin_all)
);

// File: tb/tb_anc_dual_fifo.sv
`timescale 1ns/1ps
module tb_anc_dual_fifo;
  logic arst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_n = 1'b1, sel_luma = 1'b0, rd_en_n = 1'b1, fifo_clr_n = 1'b1;
  logic int_mode = 1'b0, blank_start = 1'b0, blank_end = 1'b0, flag_oe_n = 1'b0;
  logic [19:0] wr_data = '0;
  logic [19:0] rd_data;
  logic rd_vld;
  logic [1:0] full, empty;
  int n_chk = 0, n_bad = 0;

  always #2 rd_clk = ~rd_clk;
  initial begin #1; forever #2 wr_clk = ~wr_clk; end

  anc_dual_fifo dut (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .sel_luma(sel_luma),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en_n(rd_en_n), .fifo_clr_n(fifo_clr_n),
    .int_mode(int_mode), .blank_start(blank_start), .blank_end(blank_end),
    .flag_oe_n(flag_oe_n), .rd_data(rd_data), .rd_vld(rd_vld), .full(full), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge rd_clk); endtask
  task automatic settle; repeat (4) tick(); endtask

  task automatic push(input bit luma, input logic [9:0] v);
    sel_luma = luma;
    wr_data  = luma ? {v, ~v} : {~v, v};
    wr_en_n  = 1'b0;
    tick();
    wr_en_n  = 1'b1;
  endtask

  task automatic pop(input bit luma, input logic [9:0] exp, input string req);
    sel_luma = luma;
    rd_en_n  = 1'b0;
    tick();
    rd_en_n  = 1'b1;
    chk({req, " vld"}, rd_vld, 1);
    chk({req, " data"}, luma ? rd_data[19:10] : rd_data[9:0], exp);
  endtask

  task automatic t_reset;
    chk("R11 empty", empty, 2'b11);
    chk("R11 full", full, 2'b00);
    chk("R11 vld", rd_vld, 0);
    chk("R11 data", rd_data, 0);
  endtask

  task automatic t_luma_order;
    push(1, 10'h101); push(1, 10'h102); push(1, 10'h3FF);
    settle();
    chk("R2 luma steer empty", empty, 2'b01);
    pop(1, 10'h101, "R4 order 0");
    pop(1, 10'h102, "R4 order 1");
    pop(1, 10'h3FF, "R3 pop luma");
    chk("R2 chroma half held", rd_data[9:0], 0);
    settle();
    chk("R6 empty after drain", empty, 2'b11);
  endtask

  task automatic t_chroma;
    push(0, 10'h055); push(0, 10'h2AA); push(1, 10'h1C0);
    settle();
    chk("R2 both queues", empty, 2'b00);
    pop(0, 10'h055, "R2 chroma pop");
    chk("R2 luma half held", rd_data[19:10], 10'h3FF);
    pop(1, 10'h1C0, "R2 luma pop");
    pop(0, 10'h2AA, "R2 chroma second");
  endtask

  task automatic t_hold;
    sel_luma = 1'b1;
    for (int i = 0; i < 5; i++) begin wr_data = 20'(i * 999); tick(); end
    settle();
    chk("R1 no write when high", empty, 2'b11);
    push(1, 10'h0AB);
    settle();
    rd_en_n = 1'b1;
    repeat (5) tick();
    chk("R3 no pop when high", rd_vld, 0);
    chk("R3 still queued", empty[1], 0);
    pop(1, 10'h0AB, "R3 pop after hold");
  endtask

  task automatic t_full;
    sel_luma = 1'b1;
    wr_en_n = 1'b0;
    for (int i = 0; i < 66; i++) begin
      wr_data = {10'(i * 7 + 3), 10'h000};
      tick();
    end
    wr_en_n = 1'b1;
    settle();
    chk("R5 luma full", full, 2'b10);
    for (int i = 0; i < 64; i++) pop(1, 10'(i * 7 + 3), "R4 depth readback");
    settle();
    chk("R6 empty after 64", empty, 2'b11);
    chk("R5 full clears", full, 2'b00);
    sel_luma = 1'b1; rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
    chk("R6 empty read no vld", rd_vld, 0);
    chk("R6 empty read data held", rd_data[19:10], 10'(63 * 7 + 3));
  endtask

  task automatic t_oe;
    push(0, 10'h321);
    settle();
    flag_oe_n = 1'b1;
    tick();
    chk("R8 flags forced", {full, empty}, 4'b0000);
    pop(0, 10'h321, "R8 read with flags off");
    flag_oe_n = 1'b0;
    settle();
    chk("R8 flags back", empty, 2'b11);
  endtask

  task automatic t_ext_clr;
    push(1, 10'h011); push(1, 10'h022); push(0, 10'h033);
    settle();
    fifo_clr_n = 1'b0; tick(); fifo_clr_n = 1'b1;
    chk("R7 empty during settle", empty, 2'b11);
    repeat (16) tick();
    chk("R7 empty after clear", empty, 2'b11);
    push(1, 10'h3C3);
    settle();
    pop(1, 10'h3C3, "R7 pointers restart");
    settle();
    chk("R7 nothing left", empty, 2'b11);
  endtask

  task automatic t_int;
    int got;
    int_mode = 1'b1;
    push(1, 10'h0A0); push(1, 10'h0A1); push(1, 10'h0A2); push(1, 10'h0A3);
    settle();
    rd_en_n = 1'b0; repeat (4) tick(); rd_en_n = 1'b1;
    chk("R9 rd_en_n ignored", rd_vld, 0);
    fifo_clr_n = 1'b0; tick(); fifo_clr_n = 1'b1;
    settle();
    chk("R9 fifo_clr_n ignored", empty[1], 0);
    blank_start = 1'b1; tick(); blank_start = 1'b0;
    got = 0;
    for (int k = 0; k < 10 && got < 2; k++) begin
      tick();
      if (rd_vld) begin
        chk("R9 blank read", rd_data[19:10], 10'(10'h0A0 + got));
        got++;
      end
    end
    chk("R9 two words read", got, 2);
    blank_end = 1'b1; tick(); blank_end = 1'b0;
    chk("R10 stop at blank end", rd_vld, 0);
    repeat (16) tick();
    chk("R10 leftovers discarded", empty, 2'b11);
    push(1, 10'h0B0);
    settle();
    repeat (4) tick();
    chk("R9 no read outside gap", rd_vld, 0);
    chk("R9 word kept outside gap", empty[1], 0);
    int_mode = 1'b0;
    pop(1, 10'h0B0, "R9 word after gap");
  endtask

  initial begin
    repeat (3) tick();
    arst_n = 1'b1;
    tick();
    t_reset();
    t_luma_order();
    t_chroma();
    t_hold();
    t_full();
    t_oe();
    t_ext_clr();
    t_int();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge rd_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule